// File: doc/BRIEF.md
# CAN Fault Confinement Status Unit

This block keeps the error bookkeeping of one CAN controller node. Event pulses from the protocol engine drive two saturating error counters, one for transmission and one for reception. The block derives from them two warning flags and a two-bit confinement state: error active, error passive or bus off. Bit timing, frame decoding and the bus-off recovery sequence live elsewhere and reach this block only as single-cycle pulses.

The block also latches sticky per-kind protocol error flags, which clear when the status word is read. It holds a bus-off interrupt flag that software clears by writing a one, and a mask bit that gates the interrupt request. The idle, transmitting and receiving bits follow the bus-activity inputs. A small register port with a combinational read path gives the CPU access to the status word, the counters and the control word. In freeze mode the warning flags hold their last value. In listen-only mode the reported state drops to error passive once one bit time has elapsed.

Top module: `can_fault_status`

## Requirements
- R1: Each tx_err_i pulse adds 8 to the transmit counter and each tx_ok_i pulse subtracts 1, with no step below zero. If both pulses arrive in the same cycle, the error wins. The counter reads at bits [8:0] of word 1.
- R2: Each rx_err_i pulse adds 1 to the receive counter and each rx_ok_i pulse subtracts 1, with no step below zero. The counter saturates at 511 and does not wrap. It reads at bits [24:16] of word 1.
- R3: Status bit 5 (transmit warning) is 1 exactly when the transmit counter is 96 or more. It follows the counter one cycle later.
- R4: Status bit 6 (receive warning) is 1 exactly when the receive counter is 96 or more. It follows the counter one cycle later.
- R5: While freeze_i is high, status bits 5 and 6 keep their last value. They track the counters again once freeze_i is low.
- R6: Status bits [11:10] carry the state. 00 means error active and 01 means error passive, which applies when either counter is 128 or more. 10 (any code with bit 11 set) means bus off.
- R7: Bus off applies when the transmit counter exceeds 255, and it takes precedence over error passive. While the node is bus off, both counters ignore event pulses.
- R8: A recover_i pulse clears both counters, so the state returns to error active.
- R9: Status bit 12 sets one cycle after bus off is entered. It clears only when a one is written to bit 12 of word 0; writing zero leaves it set. irq_o is high while that flag and bit 0 of word 2 (the mask) are both set.
- R10: Status bits [4:0] are sticky flags, one per err_kind_i bit, with bit 0 the stuffing error. A flag sets on its input and clears when word 0 is read with rd_en_i high. If a new event arrives in the same cycle as the read, the flag stays set.
- R11: While listen_only_i is high, the state reads 01 from the bit_cyc-th clock edge on, unless the node is bus off. Before that edge the state shows the counter-derived value. A soft_rst_i pulse restarts this delay.
- R12: Status bits 7, 8 and 9 show bus_idle_i, tx_active_i and rx_active_i as they are in the same cycle.
- R13: A soft_rst_i pulse clears both counters, the sticky flags, the warnings and the bus-off flag. It leaves the mask bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous soft reset pulse |
| freeze_i | input | 1 | Freeze mode, holds the warning flags |
| listen_only_i | input | 1 | Listen-only mode |
| tx_err_i | input | 1 | Transmit error event pulse |
| rx_err_i | input | 1 | Receive error event pulse |
| tx_ok_i | input | 1 | Successful transmit pulse |
| rx_ok_i | input | 1 | Successful receive pulse |
| recover_i | input | 1 | Bus-off recovery complete pulse |
| err_kind_i | input | 5 | Per-kind protocol error pulses, bit 0 = stuffing |
| bus_idle_i | input | 1 | Bus is idle |
| tx_active_i | input | 1 | Node is transmitting |
| rx_active_i | input | 1 | Node is receiving |
| addr_i | input | 2 | Register word select: 0 status, 1 counters, 2 control |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 32 | Register write data |
| rd_en_i | input | 1 | Register read strobe, a side effect on word 0 |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Bus-off interrupt request |

## Verification
A counter that steps wrongly shows up in word 1 at the very next sample, and in the warning or state bits one cycle later. A missed bus-off transition hides the interrupt flag one cycle after the counter crosses 255. A flag that clears too early or fails to clear shows up on the next read of word 0. The listen-only delay is checked on the edge before and the edge at which the state must change, so an off-by-one in the bit-time counter is caught.

// File: rtl/can_fs_pkg.sv
package can_fs_pkg;
  typedef enum logic [1:0] {
    CONF_ACTIVE  = 2'b00,
    CONF_PASSIVE = 2'b01,
    CONF_BUSOFF  = 2'b10
  } conf_e;

  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_COUNT  = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;

  localparam int unsigned BIT_TXWARN  = 5;
  localparam int unsigned BIT_RXWARN  = 6;
  localparam int unsigned BIT_IDLE    = 7;
  localparam int unsigned BIT_TXACT   = 8;
  localparam int unsigned BIT_RXACT   = 9;
  localparam int unsigned BIT_STATE   = 10;
  localparam int unsigned BIT_BOFFIRQ = 12;
  localparam int unsigned REC_OFFSET  = 16;
endpackage

// File: rtl/can_err_ctr.sv
module can_err_ctr #(
  parameter int unsigned W   = 9,
  parameter int unsigned INC = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         hold_i,
  input  logic         err_i,
  input  logic         ok_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W:0] MAXV = {1'b0, {W{1'b1}}};

  logic [W-1:0] cnt_q;
  logic [W:0]   sum;

  assign sum = {1'b0, cnt_q} + (W+1)'(INC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (!hold_i) begin
      if (err_i)               cnt_q <= (sum > MAXV) ? MAXV[W-1:0] : sum[W-1:0];
      else if (ok_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  // error never makes the count smaller (no wrap)
  assert_no_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i && !clr_i) |=> (cnt_q >= $past(cnt_q)));

  // success never takes zero below zero
  assert_floor_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_i && !err_i && cnt_q == '0) |=> (cnt_q == '0));

  // hold freezes the count
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/can_conf_state.sv
module can_conf_state
  import can_fs_pkg::*;
#(
  parameter int unsigned W           = 9,
  parameter int unsigned WARN_LIM    = 96,
  parameter int unsigned PASSIVE_LIM = 128,
  parameter int unsigned BOFF_LIM    = 255,
  parameter int unsigned BIT_CYC     = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         soft_rst_i,
  input  logic         freeze_i,
  input  logic         listen_only_i,
  input  logic [W-1:0] tec_i,
  input  logic [W-1:0] rec_i,
  output logic         tx_warn_o,
  output logic         rx_warn_o,
  output logic         bus_off_o,
  output conf_e        state_o
);
  localparam int unsigned LW = $clog2(BIT_CYC + 1);
  localparam logic [LW-1:0] LOM_END = LW'(BIT_CYC);

  logic          tx_warn_q, rx_warn_q;
  logic [LW-1:0] lom_cnt_q;
  logic          lom_forced;
  logic          passive;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_warn_q <= 1'b0;
      rx_warn_q <= 1'b0;
    end else if (soft_rst_i) begin
      tx_warn_q <= 1'b0;
      rx_warn_q <= 1'b0;
    end else if (!freeze_i) begin
      tx_warn_q <= (tec_i >= W'(WARN_LIM));
      rx_warn_q <= (rec_i >= W'(WARN_LIM));
    end
  end

  // one bit time after listen-only asserts, report passive
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          lom_cnt_q <= '0;
    else if (!listen_only_i || soft_rst_i) lom_cnt_q <= '0;
    else if (lom_cnt_q != LOM_END)        lom_cnt_q <= lom_cnt_q + 1'b1;
  end

  assign lom_forced = (lom_cnt_q == LOM_END);
  assign bus_off_o  = (tec_i > W'(BOFF_LIM));
  assign passive    = (tec_i >= W'(PASSIVE_LIM)) || (rec_i >= W'(PASSIVE_LIM));

  always_comb begin
    if (bus_off_o)                 state_o = CONF_BUSOFF;
    else if (passive || lom_forced) state_o = CONF_PASSIVE;
    else                           state_o = CONF_ACTIVE;
  end

  assign tx_warn_o = tx_warn_q;
  assign rx_warn_o = rx_warn_q;

  assert_freeze_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && !soft_rst_i) |=> ($stable(tx_warn_q) && $stable(rx_warn_q)));

  assert_lom_passive_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lom_forced && !bus_off_o) |-> (state_o == CONF_PASSIVE));

  assert_boff_prec_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tec_i > W'(BOFF_LIM)) |-> state_o[1]);

  assert_warn_track_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!freeze_i && !soft_rst_i) |=> (tx_warn_q == ($past(tec_i) >= W'(WARN_LIM))));
endmodule

// File: rtl/can_status_regs.sv
module can_status_regs
  import can_fs_pkg::*;
#(
  parameter int unsigned W      = 9,
  parameter int unsigned N_KIND = 5,
  parameter int unsigned DW     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic [N_KIND-1:0] err_kind_i,
  input  logic              bus_off_i,
  input  logic              tx_warn_i,
  input  logic              rx_warn_i,
  input  conf_e             state_i,
  input  logic [W-1:0]      tec_i,
  input  logic [W-1:0]      rec_i,
  input  logic              bus_idle_i,
  input  logic              tx_active_i,
  input  logic              rx_active_i,
  input  logic [1:0]        addr_i,
  input  logic              wr_en_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              rd_en_i,
  output logic [DW-1:0]     rdata_o,
  output logic              irq_o
);
  logic [N_KIND-1:0] sticky_q;
  logic              boff_d_q, boff_flag_q, mask_q;
  logic              stat_read, boff_w1c, boff_rise;

  assign stat_read = rd_en_i && (addr_i == ADDR_STATUS);
  assign boff_w1c  = wr_en_i && (addr_i == ADDR_STATUS) && wdata_i[BIT_BOFFIRQ];
  assign boff_rise = bus_off_i && !boff_d_q;

  for (genvar k = 0; k < N_KIND; k++) begin : g_sticky
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            sticky_q[k] <= 1'b0;
      else if (soft_rst_i)    sticky_q[k] <= 1'b0;
      else if (err_kind_i[k]) sticky_q[k] <= 1'b1;
      else if (stat_read)     sticky_q[k] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boff_d_q    <= 1'b0;
      boff_flag_q <= 1'b0;
    end else begin
      boff_d_q <= bus_off_i;
      if (soft_rst_i)     boff_flag_q <= 1'b0;
      else if (boff_rise) boff_flag_q <= 1'b1;
      else if (boff_w1c)  boff_flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  mask_q <= 1'b0;
    else if (wr_en_i && addr_i == ADDR_CTRL)      mask_q <= wdata_i[0];
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_STATUS: begin
        rdata_o[N_KIND-1:0]          = sticky_q;
        rdata_o[BIT_TXWARN]          = tx_warn_i;
        rdata_o[BIT_RXWARN]          = rx_warn_i;
        rdata_o[BIT_IDLE]            = bus_idle_i;
        rdata_o[BIT_TXACT]           = tx_active_i;
        rdata_o[BIT_RXACT]           = rx_active_i;
        rdata_o[BIT_STATE +: 2]      = state_i;
        rdata_o[BIT_BOFFIRQ]         = boff_flag_q;
      end
      ADDR_COUNT: begin
        rdata_o[W-1:0]               = tec_i;
        rdata_o[REC_OFFSET +: W]     = rec_i;
      end
      ADDR_CTRL:   rdata_o[0]        = mask_q;
      default:     rdata_o           = '0;
    endcase
  end

  assign irq_o = boff_flag_q && mask_q;

  assert_w0_keep_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boff_flag_q && !boff_w1c && !soft_rst_i) |=> boff_flag_q);

  assert_boff_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_off_i && !boff_d_q && !soft_rst_i) |=> boff_flag_q);

  assert_sticky_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_read && !soft_rst_i) |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));

  assert_soft_clr_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (sticky_q == '0 && !boff_flag_q));
endmodule

// File: rtl/can_fault_status.sv
module can_fault_status
  import can_fs_pkg::*;
#(
  parameter int unsigned CNT_W       = 9,
  parameter int unsigned N_KIND      = 5,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned TX_INC      = 8,
  parameter int unsigned RX_INC      = 1,
  parameter int unsigned WARN_LIM    = 96,
  parameter int unsigned PASSIVE_LIM = 128,
  parameter int unsigned BOFF_LIM    = 255,
  parameter int unsigned BIT_CYC     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              freeze_i,
  input  logic              listen_only_i,
  input  logic              tx_err_i,
  input  logic              rx_err_i,
  input  logic              tx_ok_i,
  input  logic              rx_ok_i,
  input  logic              recover_i,
  input  logic [N_KIND-1:0] err_kind_i,
  input  logic              bus_idle_i,
  input  logic              tx_active_i,
  input  logic              rx_active_i,
  input  logic [1:0]        addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] tec, rec;
  logic             bus_off, tx_warn, rx_warn, ctr_clr;
  conf_e            state;

  assign ctr_clr = soft_rst_i || recover_i;

  can_err_ctr #(.W(CNT_W), .INC(TX_INC)) i_tx_ctr (
    .clk_i, .rst_ni, .clr_i(ctr_clr), .hold_i(bus_off),
    .err_i(tx_err_i), .ok_i(tx_ok_i), .cnt_o(tec)
  );

  can_err_ctr #(.W(CNT_W), .INC(RX_INC)) i_rx_ctr (
    .clk_i, .rst_ni, .clr_i(ctr_clr), .hold_i(bus_off),
    .err_i(rx_err_i), .ok_i(rx_ok_i), .cnt_o(rec)
  );

  can_conf_state #(
    .W(CNT_W), .WARN_LIM(WARN_LIM), .PASSIVE_LIM(PASSIVE_LIM),
    .BOFF_LIM(BOFF_LIM), .BIT_CYC(BIT_CYC)
  ) i_conf (
    .clk_i, .rst_ni, .soft_rst_i, .freeze_i, .listen_only_i,
    .tec_i(tec), .rec_i(rec),
    .tx_warn_o(tx_warn), .rx_warn_o(rx_warn), .bus_off_o(bus_off), .state_o(state)
  );

  can_status_regs #(.W(CNT_W), .N_KIND(N_KIND), .DW(DATA_W)) i_regs (
    .clk_i, .rst_ni, .soft_rst_i, .err_kind_i,
    .bus_off_i(bus_off), .tx_warn_i(tx_warn), .rx_warn_i(rx_warn), .state_i(state),
    .tec_i(tec), .rec_i(rec),
    .bus_idle_i, .tx_active_i, .rx_active_i,
    .addr_i, .wr_en_i, .wdata_i, .rd_en_i, .rdata_o, .irq_o
  );

  assert_recover_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recover_i |=> (tec == '0 && rec == '0));
endmodule

// File: tb/test_can_fault_status.sv
module test_can_fault_status;
  localparam int BIT_CYC = 16;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        soft_rst_i = 0, freeze_i = 0, listen_only_i = 0;
  logic        tx_err_i = 0, rx_err_i = 0, tx_ok_i = 0, rx_ok_i = 0, recover_i = 0;
  logic [4:0]  err_kind_i = '0;
  logic        bus_idle_i = 0, tx_active_i = 0, rx_active_i = 0;
  logic [1:0]  addr_i = '0;
  logic        wr_en_i = 0, rd_en_i = 0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int checks = 0, errors = 0;

  can_fault_status #(.BIT_CYC(BIT_CYC)) i_can_fault_status (.*);

  always #10 clk_i = ~clk_i;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1; tick(); wr_en_i = 0; wdata_i = '0;
  endtask

  // kind: 0 tx_err 1 rx_err 2 tx_ok 3 rx_ok 4 recover 5 soft reset
  task automatic ev(int kind, int n);
    case (kind)
      0: tx_err_i = 1; 1: rx_err_i = 1; 2: tx_ok_i = 1;
      3: rx_ok_i = 1;  4: recover_i = 1; default: soft_rst_i = 1;
    endcase
    tick(n);
    {tx_err_i, rx_err_i, tx_ok_i, rx_ok_i, recover_i, soft_rst_i} = '0;
  endtask

  function automatic logic [31:0] tecf(logic [31:0] w); return {23'd0, w[8:0]}; endfunction
  function automatic logic [31:0] recf(logic [31:0] w); return {23'd0, w[24:16]}; endfunction

  task automatic t_reset;
    logic [31:0] d;
    rd(0, d); check("R6 reset status", d, 32'h0);
    rd(1, d); check("R1 reset counters", d, 32'h0);
    check("R9 reset irq", irq_o, 0);
  endtask

  task automatic t_tx_counter;
    logic [31:0] d;
    ev(0, 12); rd(1, d); check("R1 tec after 12 errors", tecf(d), 96);
    tick(); rd(0, d); check("R3 tx warn at 96", d[5], 1);
    ev(2, 1); rd(1, d); check("R1 tec after success", tecf(d), 95);
    tick(); rd(0, d); check("R3 tx warn below 96", d[5], 0);
    check("R6 active at 95", d[11:10], 2'b00);
    tx_err_i = 1; tx_ok_i = 1; tick(); tx_err_i = 0; tx_ok_i = 0;
    rd(1, d); check("R1 error wins over success", tecf(d), 103);
    ev(4, 1); ev(2, 3); rd(1, d); check("R1 floor at zero", tecf(d), 0);
  endtask

  task automatic t_rx_counter;
    logic [31:0] d;
    ev(1, 96); rd(1, d); check("R2 rec after 96", recf(d), 96);
    tick(); rd(0, d); check("R4 rx warn at 96", d[6], 1);
    ev(3, 100); rd(1, d); check("R2 rec floor", recf(d), 0);
    tick(); rd(0, d); check("R4 rx warn cleared", d[6], 0);
    ev(1, 600); rd(1, d); check("R2 rec saturates", recf(d), 511);
    rd(0, d); check("R6 passive from rec", d[11:10], 2'b01);
    ev(4, 1); rd(1, d); check("R8 recover clears rec", d, 0);
    rd(0, d); check("R8 active after recover", d[11:10], 2'b00);
    tick();
  endtask

  task automatic t_freeze;
    logic [31:0] d;
    freeze_i = 1; ev(0, 12); tick(2);
    rd(0, d); check("R5 tx warn frozen", d[5], 0);
    freeze_i = 0; tick();
    rd(0, d); check("R5 tx warn after freeze", d[5], 1);
    ev(4, 1); tick();
  endtask

  task automatic t_bus_off;
    logic [31:0] d;
    ev(0, 16); rd(0, d); check("R6 passive at 128", d[11:10], 2'b01);
    ev(0, 16); rd(1, d); check("R7 tec 256", tecf(d), 256);
    rd(0, d); check("R7 bus off state", d[11], 1);
    tick(); rd(0, d); check("R9 flag set on entry", d[12], 1);
    check("R9 irq masked", irq_o, 0);
    wr(2, 1); check("R9 irq unmasked", irq_o, 1);
    ev(0, 2); ev(1, 3); rd(1, d); check("R7 counters hold in bus off", d, 256);
    wr(0, 32'h0); rd(0, d); check("R9 write 0 no effect", d[12], 1);
    wr(0, 32'h1000); rd(0, d); check("R9 write 1 clears", d[12], 0);
    check("R9 irq low after clear", irq_o, 0);
    ev(4, 1); rd(1, d); check("R8 recover clears tec", d, 0);
    tick(); rd(0, d); check("R8 state active", d[12:10], 3'b000);
  endtask

  task automatic t_sticky;
    logic [31:0] d;
    err_kind_i = 5'b00001; tick(); err_kind_i = '0;
    rd(0, d); check("R10 stuff flag set", d[4:0], 5'b00001);
    rd_en_i = 1; tick(); rd_en_i = 0;
    rd(0, d); check("R10 cleared by read", d[4:0], 0);
    err_kind_i = 5'b01000; tick(); err_kind_i = 5'b01000; rd_en_i = 1; tick();
    err_kind_i = '0; rd_en_i = 0;
    rd(0, d); check("R10 set wins over read", d[4:0], 5'b01000);
    rd_en_i = 1; tick(); rd_en_i = 0;
    rd(0, d); check("R10 cleared later", d[4:0], 0);
  endtask

  task automatic t_activity;
    logic [31:0] d;
    bus_idle_i = 1; tx_active_i = 0; rx_active_i = 1;
    rd(0, d); check("R12 activity 101", d[9:7], 3'b101);
    bus_idle_i = 0; tx_active_i = 1; rx_active_i = 0;
    rd(0, d); check("R12 activity 010", d[9:7], 3'b010);
    tx_active_i = 0; tick();
  endtask

  task automatic t_listen_soft;
    logic [31:0] d;
    ev(0, 5); err_kind_i = 5'b00010; tick(); err_kind_i = '0;
    listen_only_i = 1;
    tick(BIT_CYC - 1); rd(0, d); check("R11 before one bit time", d[11:10], 2'b00);
    tick(); rd(0, d); check("R11 passive after one bit time", d[11:10], 2'b01);
    ev(5, 1); rd(0, d); check("R11 soft reset restarts delay", d[11:10], 2'b00);
    check("R13 soft reset clears sticky", d[4:0], 0);
    rd(1, d); check("R13 soft reset clears counters", d, 0);
    rd(2, d); check("R13 mask kept", d[0], 1);
    tick(BIT_CYC - 1); rd(0, d); check("R11 still active", d[11:10], 2'b00);
    tick(); rd(0, d); check("R11 passive again", d[11:10], 2'b01);
    listen_only_i = 0; tick();
    rd(0, d); check("R11 released", d[11:10], 2'b00);
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(2); rst_ni = 1; tick();
    t_reset();
    t_tx_counter();
    t_rx_counter();
    t_freeze();
    t_bus_off();
    t_sticky();
    t_activity();
    t_listen_soft();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule